// File: doc/BRIEF.md
# Line Sensor Drive Sequencer

This block produces the digital drive pattern for a self-scanning photodiode line sensor. It generates two non-overlapping phase clocks, a start pulse that opens each scan, and a separate all-reset pulse that holds every pixel in reset. Every duration is a count of system clock ticks: the phase high time, the dead gap between phases, the edge time of the external drivers, the number of pixels and the integration period.

Each frame begins with one start period, followed by one period per pixel. A period is a phase-1 pulse, a gap, a phase-2 pulse and a second gap. The start pulse covers the whole start period and the phase-1 pulse of the first pixel period, so exactly one phase-2 falling edge occurs while it is high. After the scan the outputs idle low until the integration period ends. The next frame then starts at once if `go` is still high.

Configuration is sampled only when a frame starts. The sequencer clamps every value to its legal minimum, including an integration period too short to hold the scan, and flags a too-short period on `cfg_err`.

Top module: `linescan_clkgen`

## Requirements
- R1: `phi1` and `phi2` are never high in the same cycle. Within each period `phi1` comes first.
- R2: Each `phi1` and `phi2` pulse lasts PH = max(`cfg_phase`, MIN_PH_TICKS) cycles.
- R3: The dead gap after each phase pulse is G cycles, where G is the largest of `cfg_gap`, `cfg_edge` − EDGE_FREE_TICKS (taken as 0 when negative), and the pixel-rate fill from R4. G may be 0, which gives complementary phases.
- R4: The pixel-rate fill is ceil(MIN_PIX_TICKS/2) − PH when that value is positive. This makes the period P = 2·(PH+G) at least MIN_PIX_TICKS.
- R5: `start_pulse` rises in the same cycle as the first `phi1` of a frame. It stays high through the first period and through the `phi1` pulse of the next period. Exactly one `phi2` fall occurs while it is high, and that `phi2` pulse lies entirely inside it.
- R6: A frame contains N+1 `phi2` pulses (one start period plus N pixel periods), where N = `cfg_pixels`, or 1 when `cfg_pixels` is 0.
- R7: Consecutive start pulses rise exactly T cycles apart, where T = max(`cfg_period`, (N+1)·P). Outputs stay low from the end of the scan until T elapses.
- R8: `cfg_err` is updated at each frame start. It is 1 when `cfg_period` < (N+1)·P and 0 otherwise.
- R9: A configuration change during a frame has no effect on that frame. It applies from the next frame start.
- R10: When `go` is low at the end of a frame, the sequencer stops: `busy` and all drive outputs are low from the next cycle.
- R11: A request on `arst_req` while idle drives `all_reset` high for exactly ARST_TICKS cycles. During that time no frame starts and `busy` stays low. A request while `busy` is ignored.
- R12: After reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| go | input | 1 | Run request, checked at each frame boundary |
| arst_req | input | 1 | Request for an all-reset pulse while idle |
| cfg_phase | input | TICK_W | Phase high time in ticks |
| cfg_gap | input | TICK_W | Requested dead gap in ticks |
| cfg_edge | input | TICK_W | Driver edge time in ticks |
| cfg_pixels | input | PIX_W | Pixel periods per scan |
| cfg_period | input | INT_W | Integration period in ticks |
| phi1 | output | 1 | Phase-1 clock |
| phi2 | output | 1 | Phase-2 clock |
| start_pulse | output | 1 | Scan start pulse |
| all_reset | output | 1 | All-pixel reset pulse |
| busy | output | 1 | Frame in progress |
| cfg_err | output | 1 | Last sampled period was too short |

## Verification
The bench builds the block with MIN_PH_TICKS=3, EDGE_FREE_TICKS=2, MIN_PIX_TICKS=12 and ARST_TICKS=7. At these sizes a whole frame fits in a few dozen cycles, so every cycle of every frame can be compared with a waveform computed from the requirements. These small minimums also make each clamp reachable with small settings: phase widening, the edge-derived gap, the rate fill, the zero-pixel case and the period stretch. The same sizes let the bench observe the complementary zero-gap case and the full all-reset pulse edge to edge.

// File: rtl/linescan_clkgen.sv
module linescan_clkgen #(
  parameter int TICK_W          = 16,
  parameter int PIX_W           = 12,
  parameter int INT_W           = 32,
  parameter int MIN_PH_TICKS    = 20,
  parameter int EDGE_FREE_TICKS = 2,
  parameter int MIN_PIX_TICKS   = 50,
  parameter int ARST_TICKS      = 501
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              arst_req,
  input  logic [TICK_W-1:0] cfg_phase,
  input  logic [TICK_W-1:0] cfg_gap,
  input  logic [TICK_W-1:0] cfg_edge,
  input  logic [PIX_W-1:0]  cfg_pixels,
  input  logic [INT_W-1:0]  cfg_period,
  output logic              phi1,
  output logic              phi2,
  output logic              start_pulse,
  output logic              all_reset,
  output logic              busy,
  output logic              cfg_err
);

  localparam int ARST_W  = $clog2(ARST_TICKS + 1);
  localparam int SINCE_W = $clog2(MIN_PIX_TICKS + 1);
  localparam logic [INT_W-1:0] MIN_PH = INT_W'(MIN_PH_TICKS);
  localparam logic [INT_W-1:0] EFREE  = INT_W'(EDGE_FREE_TICKS);
  localparam logic [INT_W-1:0] HALF   = INT_W'((MIN_PIX_TICKS + 1) / 2);

  typedef enum logic [2:0] {S_IDLE, S_P1, S_G1, S_P2, S_G2, S_HOLD} state_t;
  state_t state;

  logic [INT_W-1:0]  ph_r, gap_r, int_r, tcnt, fcnt;
  logic [PIX_W-1:0]  npix_r, pix;
  logic [ARST_W-1:0] arst_cnt;

  logic [INT_W-1:0] ph_w, gap_edge, gap_rate, gap_w, per_w, run_w;
  logic [PIX_W-1:0] npix_w;

  assign ph_w     = (INT_W'(cfg_phase) < MIN_PH) ? MIN_PH : INT_W'(cfg_phase);
  assign gap_edge = (INT_W'(cfg_edge) > EFREE) ? INT_W'(cfg_edge) - EFREE : '0;
  assign gap_rate = (ph_w < HALF) ? HALF - ph_w : '0;

  always_comb begin
    gap_w = INT_W'(cfg_gap);
    if (gap_edge > gap_w) gap_w = gap_edge;
    if (gap_rate > gap_w) gap_w = gap_rate;
  end

  assign npix_w = (cfg_pixels == '0) ? PIX_W'(1) : cfg_pixels;
  assign per_w  = (ph_w + gap_w) << 1;
  assign run_w  = (INT_W'(npix_w) + INT_W'(1)) * per_w;

  logic in_scan, frame_end, start_now, seg_last, per_last;
  logic [INT_W-1:0] seg_len;

  assign in_scan   = (state == S_P1) || (state == S_G1) || (state == S_P2) || (state == S_G2);
  assign busy      = (state != S_IDLE);
  assign frame_end = busy && (fcnt == int_r - INT_W'(1));
  assign start_now = busy ? (frame_end && go) : (go && !arst_req && !all_reset);
  assign seg_len   = ((state == S_P1) || (state == S_P2)) ? ph_r : gap_r;
  assign seg_last  = (tcnt == seg_len - INT_W'(1));
  assign per_last  = (pix == npix_r);

  assign phi1        = (state == S_P1);
  assign phi2        = (state == S_P2);
  assign start_pulse = (in_scan && pix == '0) || (state == S_P1 && pix == PIX_W'(1));
  assign all_reset   = (arst_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arst_cnt <= '0;
    end else if (arst_cnt != '0) begin
      arst_cnt <= arst_cnt - ARST_W'(1);
    end else if (state == S_IDLE && arst_req) begin
      arst_cnt <= ARST_W'(ARST_TICKS);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      ph_r    <= MIN_PH;
      gap_r   <= '0;
      int_r   <= '0;
      npix_r  <= PIX_W'(1);
      tcnt    <= '0;
      fcnt    <= '0;
      pix     <= '0;
      cfg_err <= 1'b0;
    end else if (start_now) begin
      ph_r    <= ph_w;
      gap_r   <= gap_w;
      npix_r  <= npix_w;
      int_r   <= (cfg_period < run_w) ? run_w : cfg_period;
      cfg_err <= (cfg_period < run_w);
      tcnt    <= '0;
      fcnt    <= '0;
      pix     <= '0;
      state   <= S_P1;
    end else if (frame_end) begin
      state <= S_IDLE;
    end else if (busy) begin
      fcnt <= fcnt + INT_W'(1);
      if (in_scan) begin
        if (!seg_last) begin
          tcnt <= tcnt + INT_W'(1);
        end else begin
          tcnt <= '0;
          unique case (state)
            S_P1: state <= (gap_r == '0) ? S_P2 : S_G1;
            S_G1: state <= S_P2;
            S_P2: begin
              if (gap_r != '0)   state <= S_G2;
              else if (per_last) state <= S_HOLD;
              else begin
                pix   <= pix + PIX_W'(1);
                state <= S_P1;
              end
            end
            default: begin
              if (per_last) state <= S_HOLD;
              else begin
                pix   <= pix + PIX_W'(1);
                state <= S_P1;
              end
            end
          endcase
        end
      end
    end
  end

  logic [INT_W-1:0]   len1, len2;
  logic [SINCE_W-1:0] since1;
  logic [1:0]         st_falls;
  logic               st_q, p1_q, p2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len1     <= '0;
      len2     <= '0;
      since1   <= SINCE_W'(MIN_PIX_TICKS);
      st_falls <= '0;
      st_q     <= 1'b0;
      p1_q     <= 1'b0;
      p2_q     <= 1'b0;
    end else begin
      st_q <= start_pulse;
      p1_q <= phi1;
      p2_q <= phi2;
      len1 <= phi1 ? len1 + INT_W'(1) : '0;
      len2 <= phi2 ? len2 + INT_W'(1) : '0;
      if (phi1 && !p1_q) since1 <= SINCE_W'(1);
      else if (since1 < SINCE_W'(MIN_PIX_TICKS)) since1 <= since1 + SINCE_W'(1);
      if (start_pulse && !st_q) st_falls <= '0;
      else if (start_pulse && p2_q && !phi2 && st_falls != 2'd3) st_falls <= st_falls + 2'd1;
    end
  end

  assert_phase_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(phi1 && phi2));

  assert_phase1_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(phi1) |-> len1 >= MIN_PH);

  assert_phase2_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(phi2) |-> len2 >= MIN_PH);

  assert_pixel_rate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phi1) |-> since1 >= SINCE_W'(MIN_PIX_TICKS));

  assert_one_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(start_pulse) |-> st_falls == 2'd1);

  assert_arst_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    all_reset |-> !busy);

  assert_arst_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    all_reset |-> !phi1 && !phi2 && !start_pulse);

endmodule

// File: tb/linescan_clkgen_test.sv
module linescan_clkgen_test;
  localparam int TICK_W = 16, PIX_W = 12, INT_W = 32;
  localparam int MPH = 3, EFREE = 2, MPIX = 12, ART = 7;

  logic clk = 0, rst_n = 0, go = 0, arst_req = 0;
  logic [TICK_W-1:0] cfg_phase = '0, cfg_gap = '0, cfg_edge = '0;
  logic [PIX_W-1:0]  cfg_pixels = '0;
  logic [INT_W-1:0]  cfg_period = '0;
  logic phi1, phi2, start_pulse, all_reset, busy, cfg_err;

  int checks = 0, errors = 0, excl_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  linescan_clkgen #(.TICK_W(TICK_W), .PIX_W(PIX_W), .INT_W(INT_W),
    .MIN_PH_TICKS(MPH), .EDGE_FREE_TICKS(EFREE), .MIN_PIX_TICKS(MPIX),
    .ARST_TICKS(ART)) uut (.*);

  always @(negedge clk) if (rst_n && phi1 && phi2) excl_bad++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic calc(input int p, input int g, input int e, input int n, input int t,
                      output int ph, output int gap, output int np, output int per, output bit err);
    int len;
    ph  = (p < MPH) ? MPH : p;
    gap = g;
    if (e - EFREE > gap) gap = e - EFREE;
    if ((MPIX + 1) / 2 - ph > gap) gap = (MPIX + 1) / 2 - ph;
    np  = (n == 0) ? 1 : n;
    len = (np + 1) * 2 * (ph + gap);
    err = (t < len);
    per = err ? len : t;
  endtask

  task automatic set_cfg(input int p, input int g, input int e, input int n, input int t);
    cfg_phase = TICK_W'(p); cfg_gap = TICK_W'(g); cfg_edge = TICK_W'(e);
    cfg_pixels = PIX_W'(n); cfg_period = INT_W'(t);
  endtask

  task automatic compare_frame(input int ph, input int gap, input int np, input int per, input string req);
    int bad = 0, first_t = -1, act_v = 0, exp_v = 0;
    int pp = 2 * (ph + gap);
    for (int t = 0; t < per; t++) begin
      logic [4:0] ex, ac;
      int k, r;
      @(negedge clk);
      k = t / pp; r = t % pp;
      ex = 5'b00010;
      if (t < (np + 1) * pp) begin
        ex[4] = (k == 0) || (k == 1 && r < ph);
        ex[3] = (r < ph);
        ex[2] = (r >= ph + gap) && (r < 2 * ph + gap);
      end
      ac = {start_pulse, phi1, phi2, busy, all_reset};
      if (ac !== ex) begin
        bad++;
        if (first_t < 0) begin first_t = t; act_v = int'(ac); exp_v = int'(ex); end
      end
    end
    check(bad == 0, req, act_v, exp_v);
    if (bad != 0) $display("  first mismatch at frame tick %0d ({st,p1,p2,busy,arst})", first_t);
  endtask

  task automatic check_stopped(input string req);
    @(negedge clk);
    check({busy, phi1, phi2, start_pulse, all_reset} == 5'b0, req,
          int'({busy, phi1, phi2, start_pulse, all_reset}), 0);
  endtask

  task automatic run_single(input int p, input int g, input int e, input int n, input int t, input string req);
    int ph, gap, np, per; bit err;
    calc(p, g, e, n, t, ph, gap, np, per, err);
    @(negedge clk);
    set_cfg(p, g, e, n, t);
    go = 1;
    fork
      compare_frame(ph, gap, np, per, req);
      begin repeat (2) @(negedge clk); go = 0; end
    join
    check_stopped({req, " R10 stop"});
    check(cfg_err == err, {req, " R8 err flag"}, int'(cfg_err), int'(err));
  endtask

  task automatic test_reset;
    check({phi1, phi2, start_pulse, all_reset, busy, cfg_err} == 6'b0, "R12 reset outputs",
          int'({phi1, phi2, start_pulse, all_reset, busy, cfg_err}), 0);
  endtask

  task automatic test_two_frames;
    int ph, gap, np, per; bit err;
    calc(4, 1, 0, 3, 100, ph, gap, np, per, err);
    @(negedge clk);
    set_cfg(4, 1, 0, 3, 100);
    go = 1;
    compare_frame(ph, gap, np, per, "R2 R5 R6 R7 frame1");
    fork
      compare_frame(ph, gap, np, per, "R4 R7 frame2 back-to-back");
      begin repeat (50) @(negedge clk); go = 0; end
    join
    check_stopped("R10 stop after frame");
    check(cfg_err == 1'b0, "R8 err clear", int'(cfg_err), 0);
  endtask

  task automatic test_midframe_change;
    int pa, ga, na, ta, pb, gb, nb, tb; bit ea, eb;
    calc(3, 3, 0, 2, 60, pa, ga, na, ta, ea);
    calc(5, 0, 4, 1, 10, pb, gb, nb, tb, eb);
    @(negedge clk);
    set_cfg(3, 3, 0, 2, 60);
    go = 1;
    fork
      compare_frame(pa, ga, na, ta, "R9 old config holds");
      begin repeat (10) @(negedge clk); set_cfg(5, 0, 4, 1, 10); end
    join
    fork
      compare_frame(pb, gb, nb, tb, "R9 new config next frame");
      begin repeat (3) @(negedge clk); go = 0; end
    join
    check_stopped("R10 stop");
    check(cfg_err == eb, "R8 err set by clamp", int'(cfg_err), int'(eb));
  endtask

  task automatic test_all_reset;
    int ph, gap, np, per, n; bit err;
    calc(3, 0, 0, 1, 30, ph, gap, np, per, err);
    @(negedge clk);
    set_cfg(3, 0, 0, 1, 30);
    go = 1; arst_req = 1;
    @(negedge clk);
    arst_req = 0;
    n = 0;
    while (all_reset && !busy && n < 20) begin n++; @(negedge clk); end
    check(n == ART, "R11 all_reset width", n, ART);
    check(!busy && !all_reset, "R11 no frame during pulse", int'({busy, all_reset}), 0);
    fork
      compare_frame(ph, gap, np, per, "R11 request while busy ignored");
      begin
        repeat (5) @(negedge clk); arst_req = 1;
        @(negedge clk); arst_req = 0; go = 0;
      end
    join
    check_stopped("R10 R11 stop");
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1;
    @(negedge clk);
    test_reset();
    test_two_frames();
    run_single(1, 0, 0, 0, 5, "R2 R4 R6 R7 clamp");
    run_single(5, 0, 6, 2, 60, "R3 edge gap");
    run_single(6, 0, 2, 2, 40, "R3 R5 complementary");
    test_midframe_change();
    test_all_reset();
    check(excl_bad == 0, "R1 phase exclusion", excl_bad, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule